// File: doc/BRIEF.md
# Instruction Line Request Controller

This block sits between a multithreaded instruction fetch unit and the instruction cache. Each cycle the fetch unit may present one fetch address with a thread number. The block clears the line-offset bits of the address and compares the result with the line it already holds for that thread. On a hit the fetch succeeds in the same cycle and the held line is driven out. On a miss it starts a cache line read over a valid/ready request port. Every request carries the thread number and a tag taken from a counter kept for each thread.

The cache may refuse a request. The block then parks that request in a single retry slot that all threads share. It raises a cache-blocked flag that stops every thread from starting new reads, and the flag stays up until the cache signals a retry. Responses return with a thread number and a tag. A response is used only if its thread is still waiting and the tag matches that thread's outstanding request. Any other response is discarded and counted. A squash on a thread abandons its outstanding read and removes its request from the retry slot.

Top module: `fetch_line_req`

## Requirements
- R1: The request address equals the fetch address with its low log2(LINE_BYTES) bits forced to zero.
- R2: When the thread's line is valid and its stored line address equals the aligned fetch address, fetch_ok is 1 in the same cycle, line_data shows the stored line, no request is driven, and the thread state becomes idle (code 0) at the next edge.
- R3: A miss from a thread in idle (0) or access-complete (4) state drives req_valid with the aligned address, the thread and its tag. At that edge the thread's line becomes invalid. If req_ready was 1, the thread moves to wait-response (code 1).
- R4: A refused new request (req_ready 0) is stored in the retry slot, sets cache_blocked, and moves the thread to wait-retry (code 2).
- R5: While cache_blocked is 1, no thread starts a new request. Hits are still served.
- R6: With mem_retry high and the slot occupied, the slot's address, thread and tag are driven again. If accepted, the thread goes to wait-response and cache_blocked clears. If refused, everything is held. With mem_retry high and the slot empty, only cache_blocked clears.
- R7: A response whose thread is not in wait-response, or whose tag differs from that thread's outstanding tag, changes no thread state or line and increments drop_cnt by one.
- R8: An accepted response stores rsp_data, marks the line valid, and moves the thread to blocked (code 3) if its stall_in bit is 1, otherwise to access-complete (code 4).
- R9: A blocked thread stays blocked while its stall_in bit is 1 and moves to access-complete when the bit is 0.
- R10: A squash sets the thread to idle. A later response to its abandoned request is dropped. A slot entry owned by that thread is removed, and cache_blocked stays set until the next mem_retry.
- R11: Each thread's tag counter starts at 0 and advances by one (modulo 2^TAG_W) on every new request, refused or not. A retry reuses the stored tag.
- R12: After reset every thread is idle, every line is invalid, the slot is empty, cache_blocked is 0 and drop_cnt is 0.
- R13: A fetch from a thread in wait-response, wait-retry or blocked state produces neither fetch_ok nor a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | Fetch address presented this cycle |
| fetch_tid | input | TID_W | Thread of the fetch |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_ok | output | 1 | Fetch hit the held line this cycle |
| line_data | output | LINE_BYTES*8 | Held line of the fetching thread |
| stall_in | input | THREADS | Downstream stall, one bit per thread |
| squash_vld | input | 1 | Squash a thread this cycle |
| squash_tid | input | TID_W | Thread being squashed |
| req_valid | output | 1 | Line read request valid |
| req_ready | input | 1 | Cache accepts the request |
| req_addr | output | ADDR_W | Line-aligned request address |
| req_tid | output | TID_W | Thread of the request |
| req_tag | output | TAG_W | Request tag |
| mem_retry | input | 1 | Cache can take a refused request again |
| rsp_valid | input | 1 | Line response valid |
| rsp_tid | input | TID_W | Thread of the response |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_data | input | LINE_BYTES*8 | Line contents |
| thr_state | output | THREADS*3 | State of each thread, 3 bits each, thread 0 lowest |
| line_valid | output | THREADS | Held line valid, one bit per thread |
| cache_blocked | output | 1 | Shared retry blocking flag |
| drop_cnt | output | CNT_W | Count of dropped responses |

## Verification
The hardest state to reach is the shared retry slot interacting with a second thread and with a squash. The slot must hold one thread's refused request while another thread misses and also hits, and then the slot's owner must be squashed so that a retry arrives with an empty slot. The stimulus reaches this by refusing a request on purpose, sending a fresh miss and a hit from the other thread while blocked, retrying once refused and once accepted, then refusing again and squashing the owner before the retry. Stale responses are made by replying with a wrong tag, replying to an idle thread, and replying to a request abandoned by a squash. After the squash, the next request for the same address must carry the incremented tag.

// File: rtl/fetch_line_req.sv
module fetch_line_req #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int THREADS    = 4,
  parameter int TAG_W      = 4,
  parameter int CNT_W      = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_vld,
  input  logic [TID_W-1:0]     fetch_tid,
  input  logic [ADDR_W-1:0]    fetch_addr,
  output logic                 fetch_ok,
  output logic [LINE_W-1:0]    line_data,
  input  logic [THREADS-1:0]   stall_in,
  input  logic                 squash_vld,
  input  logic [TID_W-1:0]     squash_tid,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [TID_W-1:0]     req_tid,
  output logic [TAG_W-1:0]     req_tag,
  input  logic                 mem_retry,
  input  logic                 rsp_valid,
  input  logic [TID_W-1:0]     rsp_tid,
  input  logic [TAG_W-1:0]     rsp_tag,
  input  logic [LINE_W-1:0]    rsp_data,
  output logic [THREADS*3-1:0] thr_state,
  output logic [THREADS-1:0]   line_valid,
  output logic                 cache_blocked,
  output logic [CNT_W-1:0]     drop_cnt
);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_WRSP  = 3'd1;
  localparam logic [2:0] S_WRTY  = 3'd2;
  localparam logic [2:0] S_BLK   = 3'd3;
  localparam logic [2:0] S_DONE  = 3'd4;

  logic [2:0]        st       [THREADS];
  logic [ADDR_W-1:0] lb_addr  [THREADS];
  logic [LINE_W-1:0] lb_data  [THREADS];
  logic [TAG_W-1:0]  tag_ctr  [THREADS];
  logic [TAG_W-1:0]  out_tag  [THREADS];
  logic [THREADS-1:0] lb_vld;

  logic              slot_vld;
  logic [ADDR_W-1:0] slot_addr;
  logic [TID_W-1:0]  slot_tid;
  logic [TAG_W-1:0]  slot_tag;
  logic              blocked;

  logic [ADDR_W-1:0] aligned;
  logic              f_squashed, can_fetch, hit, new_req, resend, rsp_ok;
  logic [2:0]        f_st;

  assign aligned    = {fetch_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign f_squashed = squash_vld && (squash_tid == fetch_tid);
  assign f_st       = st[fetch_tid];
  assign can_fetch  = fetch_vld && !f_squashed && (f_st == S_IDLE || f_st == S_DONE);
  assign hit        = lb_vld[fetch_tid] && (lb_addr[fetch_tid] == aligned);
  assign fetch_ok   = can_fetch && hit;
  assign new_req    = can_fetch && !hit && !blocked;
  assign resend     = mem_retry && slot_vld && !(squash_vld && squash_tid == slot_tid);
  assign rsp_ok     = rsp_valid && (st[rsp_tid] == S_WRSP) && (out_tag[rsp_tid] == rsp_tag)
                      && !(squash_vld && squash_tid == rsp_tid);

  assign req_valid  = resend || new_req;
  assign req_addr   = resend ? slot_addr : aligned;
  assign req_tid    = resend ? slot_tid  : fetch_tid;
  assign req_tag    = resend ? slot_tag  : tag_ctr[fetch_tid];
  assign line_data  = lb_data[fetch_tid];
  assign line_valid = lb_vld;
  assign cache_blocked = blocked;

  always_comb begin
    for (int t = 0; t < THREADS; t++) thr_state[t*3 +: 3] = st[t];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_vld <= '0;
      for (int t = 0; t < THREADS; t++) begin
        st[t]      <= S_IDLE;
        lb_addr[t] <= '0;
        lb_data[t] <= '0;
        tag_ctr[t] <= '0;
        out_tag[t] <= '0;
      end
    end else begin
      for (int t = 0; t < THREADS; t++) begin
        if (squash_vld && squash_tid == TID_W'(t)) begin
          st[t] <= S_IDLE;
        end else if (rsp_ok && rsp_tid == TID_W'(t)) begin
          lb_vld[t]  <= 1'b1;
          lb_data[t] <= rsp_data;
          st[t]      <= stall_in[t] ? S_BLK : S_DONE;
        end else if (new_req && fetch_tid == TID_W'(t)) begin
          lb_addr[t] <= aligned;
          lb_vld[t]  <= 1'b0;
          out_tag[t] <= tag_ctr[t];
          tag_ctr[t] <= tag_ctr[t] + 1'b1;
          st[t]      <= req_ready ? S_WRSP : S_WRTY;
        end else if (resend && req_ready && slot_tid == TID_W'(t)) begin
          st[t] <= S_WRSP;
        end else if (fetch_ok && fetch_tid == TID_W'(t)) begin
          st[t] <= S_IDLE;
        end else if (st[t] == S_BLK && !stall_in[t]) begin
          st[t] <= S_DONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld  <= 1'b0;
      slot_addr <= '0;
      slot_tid  <= '0;
      slot_tag  <= '0;
      blocked   <= 1'b0;
      drop_cnt  <= '0;
    end else begin
      if (new_req && !req_ready) begin
        slot_vld  <= 1'b1;
        slot_addr <= aligned;
        slot_tid  <= fetch_tid;
        slot_tag  <= tag_ctr[fetch_tid];
        blocked   <= 1'b1;
      end else if (mem_retry && blocked && !(resend && !req_ready)) begin
        slot_vld <= 1'b0;
        blocked  <= 1'b0;
      end
      if (squash_vld && slot_vld && squash_tid == slot_tid)
        slot_vld <= 1'b0;
      if (rsp_valid && !rsp_ok)
        drop_cnt <= drop_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fetch_line_req_chk.sv
module fetch_line_req_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_retry,
  input logic              cache_blocked,
  input logic              fetch_ok,
  input logic              slot_vld,
  input logic              rsp_valid,
  input logic [CNT_W-1:0]  drop_cnt
);

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[OFF_W-1:0] == '0)); // R1

  AST_HIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ok && !mem_retry) |-> !req_valid); // R2

  AST_REFUSE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> cache_blocked); // R4

  AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_blocked && !mem_retry) |-> !req_valid); // R5

  AST_SLOT_HOLDS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld |-> cache_blocked); // R6

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + 1'b1)); // R7

  AST_DROP_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> $stable(drop_cnt)); // R7

endmodule

bind fetch_line_req fetch_line_req_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .mem_retry(mem_retry), .cache_blocked(cache_blocked),
  .fetch_ok(fetch_ok), .slot_vld(slot_vld), .rsp_valid(rsp_valid), .drop_cnt(drop_cnt)
);

// File: tb/tb_fetch_line_req.sv
`timescale 1ns/1ps
module tb_fetch_line_req;
  localparam int AW = 16, LB = 16, TH = 2, TW = 3, CW = 8, LW = LB * 8;

  logic clk = 0, rst_n = 0;
  logic fetch_vld = 0, squash_vld = 0, req_ready = 0, mem_retry = 0, rsp_valid = 0;
  logic [0:0] fetch_tid = 0, squash_tid = 0, rsp_tid = 0;
  logic [AW-1:0] fetch_addr = 0;
  logic [TH-1:0] stall_in = 0;
  logic [TW-1:0] rsp_tag = 0;
  logic [LW-1:0] rsp_data = 0;
  logic fetch_ok, req_valid, cache_blocked;
  logic [LW-1:0] line_data;
  logic [AW-1:0] req_addr;
  logic [0:0] req_tid;
  logic [TW-1:0] req_tag;
  logic [TH*3-1:0] thr_state;
  logic [TH-1:0] line_valid;
  logic [CW-1:0] drop_cnt;

  int total = 0, bad = 0, exp_drop = 0;
  int exp_tag [TH];

  always #2.5 clk = ~clk;

  fetch_line_req #(.ADDR_W(AW), .LINE_BYTES(LB), .THREADS(TH), .TAG_W(TW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_tid(fetch_tid), .fetch_addr(fetch_addr),
    .fetch_ok(fetch_ok), .line_data(line_data), .stall_in(stall_in), .squash_vld(squash_vld),
    .squash_tid(squash_tid), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_tid(req_tid), .req_tag(req_tag), .mem_retry(mem_retry), .rsp_valid(rsp_valid),
    .rsp_tid(rsp_tid), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .thr_state(thr_state),
    .line_valid(line_valid), .cache_blocked(cache_blocked), .drop_cnt(drop_cnt));

  task automatic chk(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [LW-1:0] pat(logic [AW-1:0] a, int t);
    logic [15:0] w;
    w = (a & 16'hFFF0) ^ (t != 0 ? 16'hA5A5 : 16'h0000);
    return {8{w}};
  endfunction

  function automatic logic [2:0] st(int t);
    return thr_state[t*3 +: 3];
  endfunction

  task automatic idle_in();
    fetch_vld = 0; squash_vld = 0; mem_retry = 0; rsp_valid = 0; req_ready = 0;
  endtask

  task automatic fetch(int t, logic [AW-1:0] a, logic rdy);
    fetch_vld = 1; fetch_tid = 1'(t); fetch_addr = a; req_ready = rdy;
  endtask

  task automatic respond(int t, logic [TW-1:0] tg, logic [AW-1:0] a);
    rsp_valid = 1; rsp_tid = 1'(t); rsp_tag = tg; rsp_data = pat(a, t);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] a, base, last1;
    logic [TW-1:0] tg;
    for (int t = 0; t < TH; t++) exp_tag[t] = 0;
    last1 = 0;
    #7; rst_n = 1; #1;
    // R12 reset state
    chk("R12 state", LW'(thr_state), 0);
    chk("R12 line_valid", LW'(line_valid), 0);
    chk("R12 blocked", LW'(cache_blocked), 0);
    chk("R12 drop", LW'(drop_cnt), 0);
    tick();

    // sweep: miss, wait, fill (with and without stall), hit every offset
    for (int t = 0; t < TH; t++) begin
      for (int k = 0; k < 4; k++) begin
        base = AW'(16'h0100 * (k + 1) + t * 16'h0040);
        a = base + AW'((k * 5 + t * 3) % 16);
        if (t == 1) last1 = base;
        idle_in(); fetch(t, a, 1); #1;
        chk("R1 addr", LW'(req_addr), LW'(base));
        chk("R3 req_valid", LW'(req_valid), 1);
        chk("R3 req_tid", LW'(req_tid), LW'(t));
        chk("R11 tag", LW'(req_tag), LW'(exp_tag[t]));
        chk("R3 no hit", LW'(fetch_ok), 0);
        tick();
        tg = TW'(exp_tag[t]); exp_tag[t] = (exp_tag[t] + 1) % 8;
        #1;
        chk("R13 wrsp no req", LW'(req_valid), 0);
        chk("R13 wrsp no ok", LW'(fetch_ok), 0);
        chk("R3 state", LW'(st(t)), 1);
        chk("R3 line invalid", LW'(line_valid[t]), 0);
        idle_in(); respond(t, tg, a); stall_in[t] = (k % 2 == 1);
        tick();
        rsp_valid = 0;
        chk("R8 state", LW'(st(t)), (k % 2 == 1) ? 3 : 4);
        chk("R8 line valid", LW'(line_valid[t]), 1);
        if (k % 2 == 1) begin
          fetch(t, a, 1); #1;
          chk("R13 blk no ok", LW'(fetch_ok), 0);
          chk("R13 blk no req", LW'(req_valid), 0);
          tick();
          chk("R9 stays", LW'(st(t)), 3);
          fetch_vld = 0; stall_in[t] = 0;
          tick();
          chk("R9 release", LW'(st(t)), 4);
        end
        for (int o = 0; o < 16; o++) begin
          fetch(t, base + AW'(o), 1); #1;
          chk("R2 ok", LW'(fetch_ok), 1);
          chk("R2 data", line_data, pat(base, t));
          chk("R2 no req", LW'(req_valid), 0);
          tick();
          chk("R2 idle", LW'(st(t)), 0);
        end
        idle_in();
      end
    end

    // stale responses
    idle_in(); fetch(0, 16'h2000, 1); tick();
    tg = TW'(exp_tag[0]); exp_tag[0] = (exp_tag[0] + 1) % 8;
    idle_in(); respond(0, tg ^ 3'd1, 16'h2000); tick();
    exp_drop++;
    chk("R7 tag mismatch drop", LW'(drop_cnt), LW'(exp_drop));
    chk("R7 state kept", LW'(st(0)), 1);
    respond(1, 3'd0, 16'h2000); tick();
    exp_drop++;
    chk("R7 idle drop", LW'(drop_cnt), LW'(exp_drop));
    chk("R7 line kept", LW'(line_valid[1]), 1);
    chk("R7 idle state", LW'(st(1)), 0);
    respond(0, tg, 16'h2000); tick();
    rsp_valid = 0;
    chk("R8 accept", LW'(st(0)), 4);
    chk("R7 no drop on good", LW'(drop_cnt), LW'(exp_drop));

    // refusal, blocking, retry
    idle_in(); fetch(0, 16'h3004, 0); #1;
    chk("R4 req shown", LW'(req_valid), 1);
    tick();
    tg = TW'(exp_tag[0]); exp_tag[0] = (exp_tag[0] + 1) % 8;
    chk("R4 state", LW'(st(0)), 2);
    chk("R4 blocked", LW'(cache_blocked), 1);
    fetch(1, 16'h5000, 1); #1;
    chk("R5 no new req", LW'(req_valid), 0);
    fetch(1, last1 + 16'h0009, 1); #1;
    chk("R5 hit while blocked", LW'(fetch_ok), 1);
    tick();
    chk("R5 t1 idle", LW'(st(1)), 0);
    idle_in(); mem_retry = 1; req_ready = 0; #1;
    chk("R6 resend valid", LW'(req_valid), 1);
    chk("R6 resend addr", LW'(req_addr), LW'(16'h3000));
    chk("R6 resend tag", LW'(req_tag), LW'(tg));
    chk("R6 resend tid", LW'(req_tid), 0);
    tick();
    chk("R6 refused held", LW'(cache_blocked), 1);
    chk("R6 refused state", LW'(st(0)), 2);
    req_ready = 1; tick();
    idle_in();
    chk("R6 accepted state", LW'(st(0)), 1);
    chk("R6 accepted unblock", LW'(cache_blocked), 0);
    respond(0, tg, 16'h3000); tick(); rsp_valid = 0;
    chk("R8 after retry", LW'(st(0)), 4);

    // squash of slot owner, retry with empty slot
    idle_in(); fetch(1, 16'h6000, 0); tick();
    exp_tag[1] = (exp_tag[1] + 1) % 8;
    chk("R4 t1 wrty", LW'(st(1)), 2);
    idle_in(); squash_vld = 1; squash_tid = 1; tick();
    squash_vld = 0;
    chk("R10 idle", LW'(st(1)), 0);
    chk("R10 still blocked", LW'(cache_blocked), 1);
    mem_retry = 1; req_ready = 1; #1;
    chk("R6 empty slot no req", LW'(req_valid), 0);
    tick(); mem_retry = 0;
    chk("R6 empty slot unblock", LW'(cache_blocked), 0);

    // squash of outstanding request
    idle_in(); fetch(0, 16'h7000, 1); tick();
    tg = TW'(exp_tag[0]); exp_tag[0] = (exp_tag[0] + 1) % 8;
    idle_in(); squash_vld = 1; squash_tid = 0; tick();
    squash_vld = 0;
    chk("R10 squash idle", LW'(st(0)), 0);
    respond(0, tg, 16'h7000); tick(); rsp_valid = 0;
    exp_drop++;
    chk("R10 late rsp drop", LW'(drop_cnt), LW'(exp_drop));
    chk("R10 line stays invalid", LW'(line_valid[0]), 0);
    fetch(0, 16'h7000, 1); #1;
    chk("R11 new tag", LW'(req_tag), LW'(exp_tag[0]));
    chk("R11 reissue", LW'(req_valid), 1);
    tick(); idle_in();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule